// File: doc/BRIEF.md
# Robbed-Bit Signalling Inserter

This block sits in the transmit path of a 24-channel DS1 link, just before the framing-bit and line-coding stages. It accepts one channel octet per beat on a valid/ready stream. Each beat carries the frame number within the 24-frame superframe, the channel index, the transmit octet and the octet received for the same channel. It returns the octet for the line one cycle later. In every sixth frame it replaces the least significant bit of the octet with one of that channel's signalling bits. A per-channel control word can complement the octet and can select loopback of the received octet.

Signalling nibbles and control words are written through two plain write ports, one channel per write. Signalling writes land in a pending store. A frame-sync pulse copies the whole pending store into the active store that the datapath reads. The host may therefore rewrite nibbles at any point in a frame, and every beat of a frame still sees one consistent set of nibbles.

Back-pressure rules:
- A beat is accepted on a rising clock edge when `in_valid_i` and `in_ready_o` are both high.
- `in_ready_o` is high whenever the output register is empty or `out_ready_i` is high.
- While `out_valid_o` is high and `out_ready_i` is low, the output beat is held unchanged.

Top module: `rbs_inserter`

## Requirements
- R1: In a frame whose number is not a multiple of 6, the output octet equals the loopback/inversion-selected source octet, least significant bit included.
- R2: With `esf_mode_i`=1, frames 6, 12, 18 and 24 replace bit 0 of the octet with nibble bit 0 (A), bit 1 (B), bit 2 (C) and bit 3 (D) respectively.
- R3: With `esf_mode_i`=0, frames 6 and 18 insert nibble bit 0 (A), and frames 12 and 24 insert nibble bit 1 (B).
- R4: While `rbs_en_i` is low, no channel gets signalling inserted in any frame.
- R5: Control word bit 0 set to 1 stops signalling insertion for that channel only.
- R6: Control word bit 1 set to 1 complements all eight bits of the source octet, and any inserted signalling bit is then written uncomplemented.
- R7: Control word bit 2 set to 1 makes the received octet `in_rx_i` the source in place of `in_tx_i`, ahead of inversion and insertion.
- R8: A signalling write changes only the pending nibble, and the last write wins. A `frm_sync_i` pulse copies every pending nibble to the active store, and beats accepted from the next cycle onward use the copied value. A write in the same cycle as the pulse is not included in that copy.
- R9: Bits 7..1 of the output are never changed by signalling insertion.
- R10: A frame number of 0 or above 24 inserts nothing. A channel index of 24 or above passes `in_tx_i` through unchanged.
- R11: The output follows an accepted beat with one cycle of latency, `in_ready_o` = !`out_valid_o` || `out_ready_i`, and a stalled output keeps both its valid and its data stable.
- R12: After reset `out_valid_o` is low and all pending nibbles, active nibbles and control words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rbs_en_i | input | 1 | Master enable for signalling insertion |
| esf_mode_i | input | 1 | 1 = four-bit (ABCD) superframe, 0 = two-bit (AB) superframe |
| frm_sync_i | input | 1 | Frame-start pulse that copies pending nibbles to the active store |
| sig_wr_i | input | 1 | Signalling nibble write strobe |
| sig_ch_i | input | 5 | Channel addressed by the signalling write |
| sig_nib_i | input | 4 | Signalling nibble; bit 0 = A … bit 3 = D |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_ch_i | input | 5 | Channel addressed by the control write |
| cfg_word_i | input | 3 | bit 0 signalling off, bit 1 invert, bit 2 loopback |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat ready |
| in_frame_i | input | 5 | Frame number, 1 to 24 |
| in_ch_i | input | 5 | Channel index, 0 to 23 |
| in_tx_i | input | 8 | Transmit octet |
| in_rx_i | input | 8 | Received octet, used for loopback |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Output beat ready |
| out_data_o | output | 8 | Octet for the line |

## Verification
The bench builds the block with its default parameters: 24 channels, 8-bit octets, 4-bit nibbles, a 24-frame superframe and insertion every sixth frame. These values give 5-bit frame and channel fields, so the bench can drive frame numbers 0 and 25–31 and channel indices 24–31 to reach the out-of-range cases. Every one of the four insertion slots is reached in both superframe modes. A behavioural model is compared against the outputs on every clock, including during spells of randomly withheld `out_ready_i`.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  // Per-channel control word, bit 0 = signalling off, bit 1 = invert, bit 2 = loopback
  localparam int CTL_W = 3;

  typedef struct packed {
    logic loop_sel;
    logic invert;
    logic sig_off;
  } chan_ctl_t;

endpackage

// File: rtl/rbs_sig_store.sv
module rbs_sig_store #(
  parameter int NUM_CH = 24,
  parameter int NIB_W  = 4,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic [NIB_W-1:0] wr_nib_i,
  input  logic             sync_i,
  input  logic [CH_W-1:0]  rd_ch_i,
  output logic [NIB_W-1:0] rd_nib_o
);

  logic [NIB_W-1:0] pend_q [NUM_CH];
  logic [NIB_W-1:0] act_q  [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    // Host side: pending copy, last write wins
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[g] <= '0;
      end else if (wr_en_i && (wr_ch_i == CH_W'(g))) begin
        pend_q[g] <= wr_nib_i;
      end
    end

    // Line side: active copy, refreshed only at frame start
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_q[g] <= '0;
      end else if (sync_i) begin
        act_q[g] <= pend_q[g];
      end
    end

    p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_i |=> $stable(act_q[g]));

    p_active_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> act_q[g] == $past(pend_q[g]));
  end

  always_comb begin
    rd_nib_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ch_i == CH_W'(i)) rd_nib_o = act_q[i];
    end
  end

endmodule

// File: rtl/rbs_ctl_store.sv
module rbs_ctl_store
  import rbs_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic [CTL_W-1:0] wr_word_i,
  input  logic [CH_W-1:0]  rd_ch_i,
  output chan_ctl_t        rd_ctl_o
);

  chan_ctl_t ctl_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q[g] <= '0;
      end else if (wr_en_i && (wr_ch_i == CH_W'(g))) begin
        ctl_q[g] <= chan_ctl_t'(wr_word_i);
      end
    end

    p_ctl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && (wr_ch_i == CH_W'(g))) |=> $stable(ctl_q[g]));
  end

  // Out-of-range channels read an all-zero word
  always_comb begin
    rd_ctl_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ch_i == CH_W'(i)) rd_ctl_o = ctl_q[i];
    end
  end

endmodule

// File: rtl/rbs_frame_decode.sv
module rbs_frame_decode #(
  parameter int FRAMES = 24,
  parameter int PERIOD = 6,
  parameter int NIB_W  = 4,
  parameter int FR_W   = $clog2(FRAMES + 1),
  parameter int SEL_W  = $clog2(NIB_W)
) (
  input  logic [FR_W-1:0]  frame_i,
  input  logic             esf_i,
  output logic             sig_frame_o,
  output logic [SEL_W-1:0] sel_o
);

  logic [FR_W-1:0]  quot;
  logic [SEL_W-1:0] slot;

  always_comb begin
    sig_frame_o = (frame_i != '0) &&
                  (frame_i <= FR_W'(FRAMES)) &&
                  ((frame_i % FR_W'(PERIOD)) == '0);
    quot = frame_i / FR_W'(PERIOD);
    slot = SEL_W'(quot - FR_W'(1));
    // Two-bit superframe: slots alternate A, B
    if (esf_i) sel_o = slot;
    else       sel_o = {{(SEL_W-1){1'b0}}, slot[0]};
  end

endmodule

// File: rtl/rbs_inserter.sv
module rbs_inserter
  import rbs_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int OCT_W  = 8,
  parameter int NIB_W  = 4,
  parameter int FRAMES = 24,
  parameter int PERIOD = 6,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int FR_W  = $clog2(FRAMES + 1),
  localparam int SEL_W = $clog2(NIB_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rbs_en_i,
  input  logic             esf_mode_i,
  input  logic             frm_sync_i,
  input  logic             sig_wr_i,
  input  logic [CH_W-1:0]  sig_ch_i,
  input  logic [NIB_W-1:0] sig_nib_i,
  input  logic             cfg_wr_i,
  input  logic [CH_W-1:0]  cfg_ch_i,
  input  logic [CTL_W-1:0] cfg_word_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [FR_W-1:0]  in_frame_i,
  input  logic [CH_W-1:0]  in_ch_i,
  input  logic [OCT_W-1:0] in_tx_i,
  input  logic [OCT_W-1:0] in_rx_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [OCT_W-1:0] out_data_o
);

  logic [NIB_W-1:0] nib_rd;
  chan_ctl_t        ctl_rd;
  logic             sig_frame;
  logic [SEL_W-1:0] sel;
  logic             ch_ok;
  logic             accept;
  logic             insert;
  logic [OCT_W-1:0] src_oct;
  logic [OCT_W-1:0] inv_oct;
  logic [OCT_W-1:0] res_oct;

  rbs_sig_store #(.NUM_CH(NUM_CH), .NIB_W(NIB_W), .CH_W(CH_W)) u_sig (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (sig_wr_i),
    .wr_ch_i  (sig_ch_i),
    .wr_nib_i (sig_nib_i),
    .sync_i   (frm_sync_i),
    .rd_ch_i  (in_ch_i),
    .rd_nib_o (nib_rd)
  );

  rbs_ctl_store #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (cfg_wr_i),
    .wr_ch_i   (cfg_ch_i),
    .wr_word_i (cfg_word_i),
    .rd_ch_i   (in_ch_i),
    .rd_ctl_o  (ctl_rd)
  );

  rbs_frame_decode #(.FRAMES(FRAMES), .PERIOD(PERIOD), .NIB_W(NIB_W),
                     .FR_W(FR_W), .SEL_W(SEL_W)) u_dec (
    .frame_i     (in_frame_i),
    .esf_i       (esf_mode_i),
    .sig_frame_o (sig_frame),
    .sel_o       (sel)
  );

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  // Source select, then inversion, then signalling insertion
  always_comb begin
    ch_ok   = in_ch_i < CH_W'(NUM_CH);
    src_oct = ctl_rd.loop_sel ? in_rx_i : in_tx_i;
    inv_oct = ctl_rd.invert ? ~src_oct : src_oct;
    insert  = sig_frame && rbs_en_i && !ctl_rd.sig_off && ch_ok;
    res_oct = inv_oct;
    if (insert) res_oct[0] = nib_rd[sel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      if (in_ready_o) out_valid_o <= in_valid_i;
      if (accept)     out_data_o  <= res_oct;
    end
  end

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_upper_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_data_o >> 1) ==
      $past(((ctl_rd.loop_sel ? in_rx_i : in_tx_i) ^ {OCT_W{ctl_rd.invert}}) >> 1));

  p_master_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !rbs_en_i) |=> out_data_o ==
      $past((ctl_rd.loop_sel ? in_rx_i : in_tx_i) ^ {OCT_W{ctl_rd.invert}}));

endmodule

// File: tb/rbs_inserter_tb_top.sv
module rbs_inserter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rbs_en_i, esf_mode_i, frm_sync_i;
  logic       sig_wr_i;
  logic [4:0] sig_ch_i;
  logic [3:0] sig_nib_i;
  logic       cfg_wr_i;
  logic [4:0] cfg_ch_i;
  logic [2:0] cfg_word_i;
  logic       in_valid_i, in_ready_o;
  logic [4:0] in_frame_i, in_ch_i;
  logic [7:0] in_tx_i, in_rx_i;
  logic       out_valid_o, out_ready_i;
  logic [7:0] out_data_o;

  always #5 clk = ~clk;

  rbs_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .rbs_en_i(rbs_en_i), .esf_mode_i(esf_mode_i),
    .frm_sync_i(frm_sync_i), .sig_wr_i(sig_wr_i), .sig_ch_i(sig_ch_i),
    .sig_nib_i(sig_nib_i), .cfg_wr_i(cfg_wr_i), .cfg_ch_i(cfg_ch_i),
    .cfg_word_i(cfg_word_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_frame_i(in_frame_i), .in_ch_i(in_ch_i), .in_tx_i(in_tx_i),
    .in_rx_i(in_rx_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_data_o(out_data_o)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R12";
  bit    bp_mode = 0;
  int    lfsr = 32'h1234_5678;

  // Reference model state
  int   ctl_m [24];
  int   pend_m[24];
  int   act_m [24];
  bit   exp_valid;
  logic [7:0] exp_data;

  function automatic int next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >>> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  function automatic logic [7:0] ref_out(int f, int ch, logic [7:0] tx, logic [7:0] rx,
                                         bit en, bit esf);
    logic [7:0] d;
    int c, k;
    if (ch >= 24) return tx;
    c = ctl_m[ch];
    d = c[2] ? rx : tx;
    if (c[1]) d = ~d;
    if (f >= 1 && f <= 24 && (f % 6) == 0 && en && !c[0]) begin
      k = f / 6 - 1;
      if (!esf) k = k % 2;
      d[0] = act_m[ch][k];
    end
    return d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid = 0;
      exp_data  = '0;
      for (int i = 0; i < 24; i++) begin ctl_m[i] = 0; pend_m[i] = 0; act_m[i] = 0; end
    end else begin
      if (!exp_valid || out_ready_i) begin
        if (in_valid_i) begin
          exp_data  = ref_out(int'(in_frame_i), int'(in_ch_i), in_tx_i, in_rx_i,
                              rbs_en_i, esf_mode_i);
          exp_valid = 1;
        end else begin
          exp_valid = 0;
        end
      end
      if (frm_sync_i) for (int i = 0; i < 24; i++) act_m[i] = pend_m[i];
      if (cfg_wr_i && cfg_ch_i < 24) ctl_m[cfg_ch_i] = int'(cfg_word_i);
      if (sig_wr_i && sig_ch_i < 24) pend_m[sig_ch_i] = int'(sig_nib_i);
    end
  end

  // Per-clock comparison, away from the edges
  always begin
    @(negedge clk);
    #2;
    n_chk++;
    if (out_valid_o !== exp_valid) begin
      n_bad++;
      $display("FAIL %s R11: out_valid act=%0b exp=%0b", cur_req, out_valid_o, exp_valid);
    end else if (in_ready_o !== (!exp_valid || out_ready_i)) begin
      n_bad++;
      $display("FAIL %s R11: in_ready act=%0b exp=%0b", cur_req, in_ready_o,
               (!exp_valid || out_ready_i));
    end else if (exp_valid && out_data_o[7:1] !== exp_data[7:1]) begin
      n_bad++;
      $display("FAIL %s R9: out_data act=%h exp=%h", cur_req, out_data_o, exp_data);
    end else if (exp_valid && out_data_o !== exp_data) begin
      n_bad++;
      $display("FAIL %s: out_data act=%h exp=%h", cur_req, out_data_o, exp_data);
    end
  end

  // Output back-pressure
  always @(negedge clk) begin
    if (bp_mode) out_ready_i <= (next_rand() % 3) != 0;
    else         out_ready_i <= 1'b1;
  end

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=completion");
    finish_up();
  end

  task automatic write_sig(int ch, int nib);
    @(negedge clk);
    sig_wr_i = 1; sig_ch_i = 5'(ch); sig_nib_i = 4'(nib);
    @(negedge clk);
    sig_wr_i = 0;
  endtask

  task automatic write_cfg(int ch, int w);
    @(negedge clk);
    cfg_wr_i = 1; cfg_ch_i = 5'(ch); cfg_word_i = 3'(w);
    @(negedge clk);
    cfg_wr_i = 0;
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    frm_sync_i = 1;
    @(negedge clk);
    frm_sync_i = 0;
  endtask

  task automatic send_beat(int f, int ch);
    bit took;
    @(negedge clk);
    in_valid_i = 1; in_frame_i = 5'(f); in_ch_i = 5'(ch);
    in_tx_i = 8'(next_rand()); in_rx_i = 8'(next_rand());
    took = 0;
    while (!took) begin
      #1;
      took = in_ready_o;
      @(negedge clk);
    end
    in_valid_i = 0;
  endtask

  task automatic send_frame(int f, int lo, int hi);
    for (int ch = lo; ch <= hi; ch++) send_beat(f, ch);
  endtask

  task automatic run_superframe();
    for (int f = 1; f <= 24; f++) begin
      if (f % 6 != 0) cur_req = "R1";
      else cur_req = esf_mode_i ? "R2" : "R3";
      pulse_sync();
      send_frame(f, 0, 23);
    end
  endtask

  initial begin
    rst_n = 0; rbs_en_i = 1; esf_mode_i = 1; frm_sync_i = 0;
    sig_wr_i = 0; sig_ch_i = 0; sig_nib_i = 0;
    cfg_wr_i = 0; cfg_ch_i = 0; cfg_word_i = 0;
    in_valid_i = 0; in_frame_i = 0; in_ch_i = 0; in_tx_i = 0; in_rx_i = 0;
    out_ready_i = 1;
    cur_req = "R12";
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R12: stores are zero after reset, frame 6 inserts zeros
    pulse_sync();
    send_frame(6, 0, 23);

    for (int ch = 0; ch < 24; ch++) write_sig(ch, (ch * 7 + 5) % 16);
    esf_mode_i = 1;
    run_superframe();          // R1, R2
    esf_mode_i = 0;
    run_superframe();          // R1, R3

    cur_req = "R4";
    esf_mode_i = 1; rbs_en_i = 0;
    for (int f = 6; f <= 24; f += 6) send_frame(f, 0, 23);
    rbs_en_i = 1;

    cur_req = "R5";
    write_cfg(3, 1); write_cfg(10, 1);
    for (int f = 6; f <= 24; f += 6) send_frame(f, 0, 23);

    cur_req = "R6";
    write_cfg(4, 2); write_cfg(10, 3);
    for (int f = 5; f <= 24; f += 1) send_frame(f, 3, 11);

    cur_req = "R7";
    write_cfg(5, 4); write_cfg(6, 6); write_cfg(7, 7);
    for (int f = 5; f <= 24; f += 1) send_frame(f, 4, 8);

    cur_req = "R8";
    pulse_sync();
    send_frame(6, 0, 11);
    for (int ch = 0; ch < 24; ch++) write_sig(ch, 15 - (ch % 16));
    write_sig(2, 0); write_sig(2, 9);
    send_frame(6, 12, 23);
    // write in the same cycle as sync is not part of the copy
    @(negedge clk);
    frm_sync_i = 1; sig_wr_i = 1; sig_ch_i = 1; sig_nib_i = 4'h0;
    @(negedge clk);
    frm_sync_i = 0; sig_wr_i = 0;
    for (int f = 6; f <= 24; f += 6) send_frame(f, 0, 23);
    pulse_sync();
    send_frame(6, 0, 3);

    cur_req = "R10";
    send_frame(0, 0, 23);
    for (int f = 25; f <= 31; f++) send_frame(f, 0, 5);
    for (int ch = 24; ch <= 31; ch++) send_beat(6, ch);

    cur_req = "R11";
    bp_mode = 1;
    for (int f = 1; f <= 24; f++) send_frame(f, 0, 23);
    bp_mode = 0;
    repeat (4) @(negedge clk);

    finish_up();
  end

endmodule